// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle 32-bit processor datapath. On each clock it steps through one of a small set of states. From that state alone it drives every datapath control line: memory read and write strobes, instruction and program-counter write enables, register-file write, and the selects of the multiplexers at the ALU inputs, the register destination, the write-back source and the next-PC source. It never inspects data values. Its only instruction input is the 6-bit opcode field of the instruction register, which the datapath holds stable from the end of fetch until the next fetch.

Every instruction spends its first two cycles in FETCH and DECODE. After DECODE the path splits by opcode into the load, store, register-ALU, branch-if-equal, jump and add-immediate sequences. Add-immediate has no execute state of its own. It shares the address state (ADDR) of the memory instructions, where the ALU adds base register A to the sign-extended 16-bit immediate. It then finishes in IMM_WB, which writes the ALU output into the register selected by instruction bits 20-16 (destination select 0). A register-ALU instruction writes instead to the register in bits 15-11 (destination select 1). The full state list is FETCH, DECODE, ADDR, MEM_RD, LD_WB, MEM_WR, ALU_EXEC, ALU_WB, BR_DONE, JMP_DONE and IMM_WB. The transitions are:
- FETCH→DECODE always.
- DECODE→ADDR for load, store and add-immediate; DECODE→ALU_EXEC for register-ALU; DECODE→BR_DONE for branch; DECODE→JMP_DONE for jump; DECODE→FETCH for any other opcode.
- ADDR→MEM_RD for load, ADDR→MEM_WR for store, ADDR→IMM_WB for add-immediate.
- MEM_RD→LD_WB and ALU_EXEC→ALU_WB.
- LD_WB, MEM_WR, ALU_WB, BR_DONE, JMP_DONE and IMM_WB each return to FETCH.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high every output is 0. Reset is synchronous. In the first cycle after `rst` falls the outputs show the FETCH pattern.
- R2: FETCH drives `pc_wr`=1, `mem_rd`=1, `ir_wr`=1, `iord`=0, `alu_src_a`=0, `alu_src_b`=2'b01 (constant 4), `alu_op`=2'b00 (add) and `pc_src`=2'b00 (ALU result), so the PC advances by 4.
- R3: DECODE follows FETCH for every opcode and drives `alu_src_b`=2'b11 (shifted sign-extended immediate), `alu_src_a`=0 and `alu_op`=2'b00.
- R4: Load (opcode 6'b100011) runs ADDR, then MEM_RD (`mem_rd`=1, `iord`=1), then LD_WB (`reg_wr`=1, `mem_to_reg`=1, `reg_dst`=0), then FETCH. This is 5 cycles in total.
- R5: Store (opcode 6'b101011) runs ADDR, then MEM_WR (`mem_wr`=1, `iord`=1), then FETCH. This is 4 cycles.
- R6: Register-ALU (opcode 6'b000000) runs ALU_EXEC (`alu_src_a`=1, `alu_src_b`=2'b00 register B, `alu_op`=2'b10 function field), then ALU_WB (`reg_wr`=1, `reg_dst`=1, `mem_to_reg`=0). This is 4 cycles.
- R7: Branch-if-equal (opcode 6'b000100) runs BR_DONE (`pc_wr_cond`=1, `alu_src_a`=1, `alu_src_b`=2'b00, `alu_op`=2'b01 subtract, `pc_src`=2'b01 branch target). This is 3 cycles.
- R8: Jump (opcode 6'b000010) runs JMP_DONE (`pc_wr`=1, `pc_src`=2'b10 jump target). This is 3 cycles.
- R9: Add-immediate (opcode 6'b001000) runs ADDR (`alu_src_a`=1, `alu_src_b`=2'b10 sign-extended immediate, `alu_op`=2'b00), then IMM_WB (`reg_wr`=1, `mem_to_reg`=0, `reg_dst`=0). This is 4 cycles.
- R10: Any other opcode returns from DECODE to FETCH. No register, memory or PC write occurs.
- R11: Any output not named for a state is 0 in that state. `mem_rd` and `mem_wr` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst | input | 1 | synchronous reset, active high |
| opcode | input | 6 | opcode field of the held instruction |
| pc_wr | output | 1 | unconditional PC write |
| pc_wr_cond | output | 1 | PC write if ALU result is zero |
| iord | output | 1 | memory address select: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | memory read strobe |
| mem_wr | output | 1 | memory write strobe |
| ir_wr | output | 1 | instruction register write |
| mem_to_reg | output | 1 | write-back source: 0 ALU output, 1 memory data |
| reg_dst | output | 1 | destination field: 0 bits 20-16, 1 bits 15-11 |
| reg_wr | output | 1 | register-file write |
| alu_src_a | output | 1 | ALU A: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU B: 00 reg B, 01 const 4, 10 immediate, 11 immediate<<2 |
| alu_op | output | 2 | 00 add, 01 subtract, 10 by function field |
| pc_src | output | 2 | next PC: 00 ALU, 01 ALU output register, 10 jump target |

## Verification
A wrong state shows at the ports in the same cycle it is entered, because the outputs are a pure function of the state register. A bad transition is therefore seen one clock after the faulty edge. This is most visible when add-immediate picks the register-ALU destination select, or when an unknown opcode leaves a write strobe active. The bench compares the full output word against the expected state pattern in every cycle of each instruction sequence. A missing or extra state then also shows as a wrong instruction length.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OP_W  = 6;
    localparam int SEL_W = 2;

    localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OP_JUMP  = 6'b000010;
    localparam logic [OP_W-1:0] OP_ADDI  = 6'b001000;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_ADDR, ST_MEM_RD, ST_LD_WB, ST_MEM_WR,
        ST_ALU_EXEC, ST_ALU_WB, ST_BR_DONE, ST_JMP_DONE, ST_IMM_WB
    } state_t;

    typedef enum logic [2:0] {
        CL_LOAD, CL_STORE, CL_RTYPE, CL_BEQ, CL_JUMP, CL_ADDI, CL_BAD
    } op_class_t;

    typedef struct packed {
        logic             pc_wr;
        logic             pc_wr_cond;
        logic             iord;
        logic             mem_rd;
        logic             mem_wr;
        logic             ir_wr;
        logic             mem_to_reg;
        logic             reg_dst;
        logic             reg_wr;
        logic             alu_src_a;
        logic [SEL_W-1:0] alu_src_b;
        logic [SEL_W-1:0] alu_op;
        logic [SEL_W-1:0] pc_src;
    } ctrl_t;

endpackage

// File: rtl/mc_op_class.sv
module mc_op_class
    import mc_ctrl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_class_t       op_class
);
    always_comb begin
        unique case (opcode)
            OP_LOAD:  op_class = CL_LOAD;
            OP_STORE: op_class = CL_STORE;
            OP_RTYPE: op_class = CL_RTYPE;
            OP_BEQ:   op_class = CL_BEQ;
            OP_JUMP:  op_class = CL_JUMP;
            OP_ADDI:  op_class = CL_ADDI;
            default:  op_class = CL_BAD;
        endcase
    end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
    import mc_ctrl_pkg::*;
(
    input  state_t    cur,
    input  op_class_t op_class,
    output state_t    nxt
);
    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (op_class)
                    CL_LOAD, CL_STORE, CL_ADDI: nxt = ST_ADDR;
                    CL_RTYPE: nxt = ST_ALU_EXEC;
                    CL_BEQ:   nxt = ST_BR_DONE;
                    CL_JUMP:  nxt = ST_JMP_DONE;
                    default:  nxt = ST_FETCH;
                endcase
            end
            ST_ADDR: begin
                unique case (op_class)
                    CL_LOAD:  nxt = ST_MEM_RD;
                    CL_STORE: nxt = ST_MEM_WR;
                    CL_ADDI:  nxt = ST_IMM_WB;
                    default:  nxt = ST_FETCH;
                endcase
            end
            ST_MEM_RD:   nxt = ST_LD_WB;
            ST_ALU_EXEC: nxt = ST_ALU_WB;
            default:     nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
    import mc_ctrl_pkg::*;
(
    input  state_t cur,
    output ctrl_t  ctl
);
    always_comb begin
        ctl = '0;
        unique case (cur)
            ST_FETCH: begin
                ctl.pc_wr     = 1'b1;
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.alu_src_b = 2'b01;
            end
            ST_DECODE: ctl.alu_src_b = 2'b11;
            ST_ADDR: begin
                ctl.alu_src_a = 1'b1;
                ctl.alu_src_b = 2'b10;
            end
            ST_MEM_RD: begin
                ctl.mem_rd = 1'b1;
                ctl.iord   = 1'b1;
            end
            ST_LD_WB: begin
                ctl.reg_wr     = 1'b1;
                ctl.mem_to_reg = 1'b1;
            end
            ST_MEM_WR: begin
                ctl.mem_wr = 1'b1;
                ctl.iord   = 1'b1;
            end
            ST_ALU_EXEC: begin
                ctl.alu_src_a = 1'b1;
                ctl.alu_op    = 2'b10;
            end
            ST_ALU_WB: begin
                ctl.reg_wr  = 1'b1;
                ctl.reg_dst = 1'b1;
            end
            ST_BR_DONE: begin
                ctl.pc_wr_cond = 1'b1;
                ctl.alu_src_a  = 1'b1;
                ctl.alu_op     = 2'b01;
                ctl.pc_src     = 2'b01;
            end
            ST_JMP_DONE: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = 2'b10;
            end
            ST_IMM_WB: ctl.reg_wr = 1'b1;
            default:   ctl = '0;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  opcode,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             iord,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_wr,
    output logic             mem_to_reg,
    output logic             reg_dst,
    output logic             reg_wr,
    output logic             alu_src_a,
    output logic [SEL_W-1:0] alu_src_b,
    output logic [SEL_W-1:0] alu_op,
    output logic [SEL_W-1:0] pc_src
);
    state_t    state_q;
    state_t    state_d;
    op_class_t op_class;
    ctrl_t     ctl;
    ctrl_t     ctl_gated;

    mc_op_class u_class (
        .opcode   (opcode),
        .op_class (op_class)
    );

    mc_next_state u_next (
        .cur      (state_q),
        .op_class (op_class),
        .nxt      (state_d)
    );

    mc_ctrl_out u_out (
        .cur (state_q),
        .ctl (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    // all strobes held low while reset is applied
    assign ctl_gated = rst ? '0 : ctl;

    assign pc_wr      = ctl_gated.pc_wr;
    assign pc_wr_cond = ctl_gated.pc_wr_cond;
    assign iord       = ctl_gated.iord;
    assign mem_rd     = ctl_gated.mem_rd;
    assign mem_wr     = ctl_gated.mem_wr;
    assign ir_wr      = ctl_gated.ir_wr;
    assign mem_to_reg = ctl_gated.mem_to_reg;
    assign reg_dst    = ctl_gated.reg_dst;
    assign reg_wr     = ctl_gated.reg_wr;
    assign alu_src_a  = ctl_gated.alu_src_a;
    assign alu_src_b  = ctl_gated.alu_src_b;
    assign alu_op     = ctl_gated.alu_op;
    assign pc_src     = ctl_gated.pc_src;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk (
    input logic       clk,
    input logic       rst,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_wr,
    input logic       mem_to_reg,
    input logic       reg_dst,
    input logic       reg_wr,
    input logic [1:0] alu_src_b
);
    assert_quiet_in_reset_R1: assert property (@(posedge clk)
        rst |-> !(pc_wr || pc_wr_cond || mem_rd || mem_wr || ir_wr || reg_wr));

    assert_fetch_after_reset_R1: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (ir_wr && pc_wr && mem_rd));

    assert_decode_follows_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (!ir_wr && alu_src_b == 2'b11));

    assert_writeback_ends_R4: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> ir_wr);

    assert_addi_from_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_dst && !mem_to_reg) |-> $past(alu_src_b) == 2'b10);

    assert_no_rd_wr_clash_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .ir_wr      (ir_wr),
    .mem_to_reg (mem_to_reg),
    .reg_dst    (reg_dst),
    .reg_wr     (reg_wr),
    .alu_src_b  (alu_src_b)
);

// File: tb/test_mc_ctrl_fsm.sv
`timescale 1ns/100ps
module test_mc_ctrl_fsm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b0;
    logic       pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr;
    logic       mem_to_reg, reg_dst, reg_wr, alu_src_a;
    logic [1:0] alu_src_b, alu_op, pc_src;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mc_ctrl_fsm i_mc_ctrl_fsm (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .iord(iord),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
        .mem_to_reg(mem_to_reg), .reg_dst(reg_dst), .reg_wr(reg_wr),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
        .alu_op(alu_op), .pc_src(pc_src)
    );

    // {pc_wr,pc_wr_cond,iord,mem_rd,mem_wr,ir_wr,mem_to_reg,reg_dst,reg_wr,alu_src_a,srcb,aluop,pcsrc}
    function automatic logic [15:0] word();
        return {pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, mem_to_reg,
                reg_dst, reg_wr, alu_src_a, alu_src_b, alu_op, pc_src};
    endfunction

    task automatic check(input logic [15:0] exp, input int req, input string what);
        logic [15:0] act;
        act = word();
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // vector: {req[3:0], opcode[5:0], expected word[15:0]}
    localparam logic [25:0] VEC [26] = '{
        {4'd2, 6'h23, 16'h9410}, {4'd3, 6'h23, 16'h0030},  // R2 R3 load
        {4'd4, 6'h23, 16'h0060}, {4'd4, 6'h23, 16'h3000},  // R4
        {4'd4, 6'h23, 16'h0280},
        {4'd2, 6'h2B, 16'h9410}, {4'd3, 6'h2B, 16'h0030},  // store
        {4'd5, 6'h2B, 16'h0060}, {4'd5, 6'h2B, 16'h2800},  // R5
        {4'd2, 6'h00, 16'h9410}, {4'd3, 6'h00, 16'h0030},  // register-ALU
        {4'd6, 6'h00, 16'h0048}, {4'd6, 6'h00, 16'h0180},  // R6
        {4'd2, 6'h04, 16'h9410}, {4'd3, 6'h04, 16'h0030},  // branch
        {4'd7, 6'h04, 16'h4045},                           // R7
        {4'd2, 6'h02, 16'h9410}, {4'd3, 6'h02, 16'h0030},  // jump
        {4'd8, 6'h02, 16'h8002},                           // R8
        {4'd2, 6'h08, 16'h9410}, {4'd3, 6'h08, 16'h0030},  // add-immediate
        {4'd9, 6'h08, 16'h0060}, {4'd9, 6'h08, 16'h0080},  // R9
        {4'd2, 6'h3F, 16'h9410}, {4'd10, 6'h3F, 16'h0030}, // R10 unknown
        {4'd2, 6'h3F, 16'h9410}                            // back in fetch
    };

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(16'h0000, 1, "outputs during reset");
        rst = 1'b0;
        #1 check(16'h9410, 1, "fetch after reset release");
        @(negedge clk);
        @(negedge clk);
        // now in FETCH again? no: realign by reset pulse
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < 26; i++) begin
            opcode = VEC[i][21:16];
            #1;
            check(VEC[i][15:0], int'(VEC[i][25:22]), $sformatf("sequence step %0d", i));
            total++;
            if (mem_rd && mem_wr) begin
                bad++;
                $display("FAIL R11 step %0d: actual=rd+wr expected=exclusive", i);
            end
            @(negedge clk);
        end

        // R10: near-miss opcode, two cycles then fetch, no writes
        opcode = 6'b000001;
        #1 check(16'h0030, 10, "decode of unlisted opcode");
        @(negedge clk);
        #1 check(16'h9410, 10, "unlisted opcode returns to fetch");

        // R1: reset in the middle of a load
        opcode = 6'h23;
        @(negedge clk);
        @(negedge clk);
        #1 check(16'h0060, 4, "load address state before reset");
        rst = 1'b1;
        #1 check(16'h0000, 1, "outputs forced low by reset");
        @(negedge clk);
        #1 check(16'h0000, 1, "outputs low across reset edge");
        rst = 1'b0;
        #1 check(16'h9410, 1, "fetch after mid-instruction reset");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule